// File: doc/BRIEF.md
# Triggered Burst Capture Streamer

This block records one burst of complex baseband samples for each software trigger and sends it out on a 128-bit AXI4-Stream master toward a stream-to-memory DMA. Every sample is complex, with a 16-bit real half and a 16-bit imaginary half. Four samples travel together in each output beat. One frame is 512 samples, which is 128 beats. A burst is a configurable number of consecutive frames. When the burst ends, the block returns to idle and waits for the next trigger.

A source select picks the payload. It is either the live four-sample-wide input or a built-in counting pattern. In the pattern, the real half of each sample carries the sample position inside its frame and the imaginary half carries the frame number. Software can use it to confirm ordering, frame alignment and continuity in memory. The frame count and the source select are sampled when a trigger is accepted. A busy flag covers the whole burst. A sticky overflow flag records live samples lost to backpressure, and a saturating counter records triggers that arrived while busy.

Top module: `burst_streamer`

## Requirements
- R1: After reset, mTvalid, busy and overflowFlag are 0 and missedCount is 0.
- R2: A trigIn pulse seen while idle, with nFramesCfg nonzero, raises busy from the next cycle. Busy stays high until the clock edge at which the beat carrying mTlast is accepted, and it is low after that edge.
- R3: An accepted trigger produces exactly 128*nFrames transferred beats. mTlast is high on the last of them and on no other beat.
- R4: Pattern mode (patternSel=1) fills lane i, bits [32i+31:32i], as follows for i=0..3. The low 16 bits hold the sample index inside the frame (4*beatInFrame+i, 0..511). The high 16 bits hold the frame index, which starts at 0 for each burst and wraps modulo 2^16.
- R5: In live mode (patternSel=0), each liveData word taken while liveValid is high becomes one beat unchanged. liveValid has no effect while idle.
- R6: While mTvalid is high and mTready is low, mTvalid stays high and mTdata and mTlast hold their values.
- R7: overflowFlag is set when, during a live-mode burst that has not yet produced its final beat, liveValid is high while the output beat is held by backpressure. The flag stays set until overflowClr is pulsed. If set and clear happen in the same cycle, set wins.
- R8: A trigIn pulse while busy is high has no effect on the running burst. It increments missedCount, which saturates at its all-ones value.
- R9: nFramesCfg and patternSel are sampled when a trigger is accepted. Changing them during a burst changes neither its length nor its source.
- R10: A trigIn pulse while idle with nFramesCfg equal to 0 starts nothing and leaves missedCount unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Software trigger, one-cycle pulse |
| nFramesCfg | input | 16 | Frames per burst, sampled at trigger |
| patternSel | input | 1 | 1 selects the counting pattern, 0 the live input |
| liveData | input | 128 | Four live samples, lane i in bits [32i+31:32i] |
| liveValid | input | 1 | liveData holds new samples this cycle |
| overflowClr | input | 1 | Clears the overflow flag |
| mTdata | output | 128 | Stream data |
| mTvalid | output | 1 | Stream valid |
| mTready | input | 1 | Stream ready from the DMA |
| mTlast | output | 1 | Final beat of the burst |
| busy | output | 1 | Burst in progress |
| overflowFlag | output | 1 | Sticky: live samples dropped |
| missedCount | output | 8 | Saturating count of ignored triggers |

## Verification
Pattern bursts with mTready held high show that the beat count, the lane order and the frame rollover are right at full rate. Pattern bursts with random ready stalls, with the frame count and source changed mid-burst, separate a correct hold and a trigger-time snapshot from designs that skip, repeat or re-read configuration. Live bursts with random valid and ready show that words pass through unchanged and mark exactly the dropped samples as overflow. A burst flooded with triggers, a zero-frame trigger and idle live traffic expose counter saturation and inputs that should be ignored.

// File: rtl/bcap_pkg.sv
package bcap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN
  } bcapState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic last;
    logic usePattern;
  } bcapStrobe_t;

endpackage

// File: rtl/bcap_pattern.sv
module bcap_pattern #(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 16,
  parameter int BEAT_W   = 7,
  parameter int NFR_W    = 16,
  localparam int DATA_W  = LANES * 2 * SAMPLE_W
) (
  input  logic [BEAT_W-1:0] beatIdx,
  input  logic [NFR_W-1:0]  frameIdx,
  output logic [DATA_W-1:0] patWord
);

  logic [SAMPLE_W-1:0] imagVal;
  assign imagVal = SAMPLE_W'(frameIdx);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SAMPLE_W-1:0] realVal;
    assign realVal = SAMPLE_W'(32'(beatIdx) * LANES + i);
    assign patWord[i*2*SAMPLE_W +: 2*SAMPLE_W] = {imagVal, realVal};
  end

endmodule

// File: rtl/bcap_ctrl.sv
module bcap_ctrl
  import bcap_pkg::*;
#(
  parameter int BEATS_PER_FRAME = 128,
  parameter int BEAT_W          = 7,
  parameter int NFR_W           = 16,
  parameter int MISS_W          = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic [NFR_W-1:0]  nFramesCfg,
  input  logic              patternSel,
  input  logic              liveValid,
  input  logic              overflowClr,
  input  logic              slotFree,
  input  logic              xferLast,
  output bcapStrobe_t       strb,
  output logic [BEAT_W-1:0] beatIdx,
  output logic [NFR_W-1:0]  frameIdx,
  output logic              busy,
  output logic              overflowFlag,
  output logic [MISS_W-1:0] missedCount
);

  localparam logic [BEAT_W-1:0] BEAT_MAX = BEAT_W'(BEATS_PER_FRAME - 1);

  bcapState_t       state;
  logic [NFR_W-1:0] nFramesLat;
  logic             patLat;
  logic             srcReady;
  logic             loadNow;
  logic             lastBeat;
  logic             startNow;

  assign srcReady = patLat || liveValid;
  assign loadNow  = (state == ST_RUN) && srcReady && slotFree;
  assign lastBeat = (beatIdx == BEAT_MAX) && (frameIdx == nFramesLat - 1'b1);
  assign startNow = trigIn && (state == ST_IDLE) && (nFramesCfg != '0);
  assign busy     = (state != ST_IDLE);

  assign strb.load       = loadNow;
  assign strb.last       = lastBeat;
  assign strb.usePattern = patLat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      nFramesLat <= '0;
      patLat     <= 1'b0;
      beatIdx    <= '0;
      frameIdx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startNow) begin
            state      <= ST_RUN;
            nFramesLat <= nFramesCfg;
            patLat     <= patternSel;
            beatIdx    <= '0;
            frameIdx   <= '0;
          end
        end
        ST_RUN: begin
          if (loadNow) begin
            if (beatIdx == BEAT_MAX) begin
              beatIdx  <= '0;
              frameIdx <= frameIdx + 1'b1;
            end else begin
              beatIdx <= beatIdx + 1'b1;
            end
            if (lastBeat) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (xferLast) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overflowFlag <= 1'b0;
    end else if ((state == ST_RUN) && !patLat && liveValid && !slotFree) begin
      overflowFlag <= 1'b1;
    end else if (overflowClr) begin
      overflowFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missedCount <= '0;
    end else if (trigIn && busy && !(&missedCount)) begin
      missedCount <= missedCount + 1'b1;
    end
  end

endmodule

// File: rtl/bcap_datapath.sv
module bcap_datapath
  import bcap_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  bcapStrobe_t       strb,
  input  logic [DATA_W-1:0] liveData,
  input  logic [DATA_W-1:0] patWord,
  input  logic              mTready,
  output logic [DATA_W-1:0] mTdata,
  output logic              mTvalid,
  output logic              mTlast,
  output logic              slotFree,
  output logic              xferLast
);

  logic [DATA_W-1:0] srcWord;

  assign srcWord  = strb.usePattern ? patWord : liveData;
  assign slotFree = !mTvalid || mTready;
  assign xferLast = mTvalid && mTready && mTlast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mTvalid <= 1'b0;
      mTdata  <= '0;
      mTlast  <= 1'b0;
    end else if (strb.load) begin
      mTvalid <= 1'b1;
      mTdata  <= srcWord;
      mTlast  <= strb.last;
    end else if (mTready) begin
      mTvalid <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_streamer.sv
module burst_streamer
  import bcap_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int SAMPLE_W  = 16,
  parameter int FRAME_LEN = 512,
  parameter int NFR_W     = 16,
  parameter int MISS_W    = 8,
  localparam int DATA_W          = LANES * 2 * SAMPLE_W,
  localparam int BEATS_PER_FRAME = FRAME_LEN / LANES,
  localparam int BEAT_W          = $clog2(BEATS_PER_FRAME)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic [NFR_W-1:0]  nFramesCfg,
  input  logic              patternSel,
  input  logic [DATA_W-1:0] liveData,
  input  logic              liveValid,
  input  logic              overflowClr,
  output logic [DATA_W-1:0] mTdata,
  output logic              mTvalid,
  input  logic              mTready,
  output logic              mTlast,
  output logic              busy,
  output logic              overflowFlag,
  output logic [MISS_W-1:0] missedCount
);

  bcapStrobe_t       strb;
  logic [BEAT_W-1:0] beatIdx;
  logic [NFR_W-1:0]  frameIdx;
  logic [DATA_W-1:0] patWord;
  logic              slotFree;
  logic              xferLast;

  bcap_ctrl #(
    .BEATS_PER_FRAME(BEATS_PER_FRAME),
    .BEAT_W(BEAT_W),
    .NFR_W(NFR_W),
    .MISS_W(MISS_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .nFramesCfg(nFramesCfg),
    .patternSel(patternSel), .liveValid(liveValid), .overflowClr(overflowClr),
    .slotFree(slotFree), .xferLast(xferLast), .strb(strb),
    .beatIdx(beatIdx), .frameIdx(frameIdx), .busy(busy),
    .overflowFlag(overflowFlag), .missedCount(missedCount)
  );

  bcap_pattern #(
    .LANES(LANES), .SAMPLE_W(SAMPLE_W), .BEAT_W(BEAT_W), .NFR_W(NFR_W)
  ) u_pattern (
    .beatIdx(beatIdx), .frameIdx(frameIdx), .patWord(patWord)
  );

  bcap_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .liveData(liveData),
    .patWord(patWord), .mTready(mTready), .mTdata(mTdata),
    .mTvalid(mTvalid), .mTlast(mTlast), .slotFree(slotFree),
    .xferLast(xferLast)
  );

endmodule

// File: rtl/burst_streamer_chk.sv
module burst_streamer_chk #(
  parameter int DATA_W = 128,
  parameter int MISS_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              trigIn,
  input logic              overflowClr,
  input logic [DATA_W-1:0] mTdata,
  input logic              mTvalid,
  input logic              mTready,
  input logic              mTlast,
  input logic              busy,
  input logic              overflowFlag,
  input logic [MISS_W-1:0] missedCount
);

  // R6
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    mTvalid && !mTready |=> mTvalid && $stable(mTdata) && $stable(mTlast));

  // R2
  valid_in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    mTvalid |-> busy);

  // R2
  last_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    mTvalid && mTready && mTlast |=> !busy);

  // R8
  missed_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && trigIn && !(&missedCount) |=> missedCount == MISS_W'($past(missedCount) + 1'b1));

  // R8
  missed_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    &missedCount |=> &missedCount);

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag && !overflowClr |=> overflowFlag);

endmodule

bind burst_streamer burst_streamer_chk #(.DATA_W(DATA_W), .MISS_W(MISS_W)) u_chk (
  .clk(clk), .rstN(rstN), .trigIn(trigIn), .overflowClr(overflowClr),
  .mTdata(mTdata), .mTvalid(mTvalid), .mTready(mTready), .mTlast(mTlast),
  .busy(busy), .overflowFlag(overflowFlag), .missedCount(missedCount)
);

// File: tb/burst_streamer_tb.sv
module burst_streamer_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         trigIn = 1'b0;
  logic [15:0]  nFramesCfg = 16'd0;
  logic         patternSel = 1'b0;
  logic [127:0] liveData = '0;
  logic         liveValid = 1'b0;
  logic         overflowClr = 1'b0;
  logic [127:0] mTdata;
  logic         mTvalid;
  logic         mTready = 1'b1;
  logic         mTlast;
  logic         busy;
  logic         overflowFlag;
  logic [7:0]   missedCount;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit readyRand = 0;
  bit liveRand = 0;
  bit cmpOn = 0;
  int xferCount = 0;

  always #2 clk = ~clk;

  burst_streamer u_dut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .nFramesCfg(nFramesCfg),
    .patternSel(patternSel), .liveData(liveData), .liveValid(liveValid),
    .overflowClr(overflowClr), .mTdata(mTdata), .mTvalid(mTvalid),
    .mTready(mTready), .mTlast(mTlast), .busy(busy),
    .overflowFlag(overflowFlag), .missedCount(missedCount)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
    end
  endtask

  // behavioural reference model
  bit           mBusy, mRun, mPat, mValid, mLast, mOvf;
  int           gen, total, mMissed;
  logic [127:0] mData;

  function automatic logic [127:0] patBeat(input int g);
    logic [127:0] w;
    for (int i = 0; i < 4; i++) begin
      w[i*32 +: 16]      = 16'((g % 128) * 4 + i);
      w[i*32 + 16 +: 16] = 16'(g / 128);
    end
    return w;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mBusy = 0; mRun = 0; mPat = 0; mValid = 0; mLast = 0; mOvf = 0;
      gen = 0; total = 0; mMissed = 0; mData = '0;
    end else begin
      bit free, endXfer, ld, start;
      free    = !mValid || mTready;
      endXfer = mValid && mTready && mLast;
      ld      = mRun && (mPat || liveValid) && free;
      start   = trigIn && !mBusy && (nFramesCfg != 0);
      if (mRun && !mPat && liveValid && !free) mOvf = 1;
      else if (overflowClr) mOvf = 0;
      if (trigIn && mBusy && mMissed != 255) mMissed++;
      if (ld) begin
        mValid = 1;
        mLast  = (gen == total - 1);
        mData  = mPat ? patBeat(gen) : liveData;
        gen++;
        if (gen == total) mRun = 0;
      end else if (mTready) begin
        mValid = 0;
      end
      if (endXfer) mBusy = 0;
      if (start) begin
        mBusy = 1; mRun = 1; gen = 0; total = 128 * nFramesCfg; mPat = patternSel;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmpOn) begin
      check("R2 busy", 128'(busy), 128'(mBusy));
      check("R6 valid", 128'(mTvalid), 128'(mValid));
      check("R7 overflow", 128'(overflowFlag), 128'(mOvf));
      check("R8 missed", 128'(missedCount), 128'(mMissed));
      if (mValid) begin
        check("R3 last", 128'(mTlast), 128'(mLast));
        check(mPat ? "R4 pattern data" : "R5 live data", mTdata, mData);
      end
      if (mTvalid && mTready) xferCount++;
    end
  end

  // random stimulus streams
  always @(posedge clk) begin
    #1;
    mTready   <= readyRand ? 1'($urandom % 2) : 1'b1;
    liveValid <= liveRand ? 1'($urandom % 2) : 1'b0;
    liveData  <= {$urandom, $urandom, $urandom, $urandom};
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulseTrig(input int frames, input bit pat);
    nFramesCfg = 16'(frames);
    patternSel = pat;
    trigIn = 1'b1;
    tick(1);
    trigIn = 1'b0;
  endtask

  task automatic waitIdle();
    tick(1);
    while (busy) tick(1);
    tick(1);
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid reset", 128'(mTvalid), 128'd0);
    check("R1 busy reset", 128'(busy), 128'd0);
    check("R1 overflow reset", 128'(overflowFlag), 128'd0);
    check("R1 missed reset", 128'(missedCount), 128'd0);
    cmpOn = 1;
    tick(1);

    // R3 R4: pattern, full rate, two frames
    xferCount = 0;
    pulseTrig(2, 1);
    waitIdle();
    check("R3 beats in 2-frame burst", 128'(xferCount), 128'd256);

    // R6 R8 R9: pattern with stalls, config changed and trigger mid-burst
    readyRand = 1;
    xferCount = 0;
    pulseTrig(3, 1);
    tick(40);
    nFramesCfg = 16'd1;
    patternSel = 1'b0;
    trigIn = 1'b1; tick(1); trigIn = 1'b0;
    waitIdle();
    check("R9 length from trigger-time snapshot", 128'(xferCount), 128'd384);
    check("R8 one missed trigger", 128'(missedCount), 128'd1);

    // R5 R7: live, random valid and ready
    liveRand = 1;
    xferCount = 0;
    pulseTrig(1, 0);
    waitIdle();
    check("R5 live beats", 128'(xferCount), 128'd128);
    check("R7 overflow matches model", 128'(overflowFlag), 128'(mOvf));
    overflowClr = 1'b1; tick(1); overflowClr = 1'b0;
    @(negedge clk);
    check("R7 overflow cleared", 128'(overflowFlag), 128'd0);

    // R5: live traffic while idle produces nothing
    xferCount = 0;
    tick(50);
    liveRand = 0;
    check("R5 idle live ignored", 128'(xferCount), 128'd0);

    // R10: zero-frame trigger
    pulseTrig(0, 1);
    tick(2);
    @(negedge clk);
    check("R10 zero frames no busy", 128'(busy), 128'd0);
    check("R10 missed unchanged", 128'(missedCount), 128'd1);

    // R8: saturation under a trigger flood
    readyRand = 0;
    pulseTrig(4, 1);
    trigIn = 1'b1;
    tick(300);
    trigIn = 1'b0;
    waitIdle();
    check("R8 missed saturates", 128'(missedCount), 128'd255);

    cmpOn = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule